// File: doc/BRIEF.md
# Quad I/O Word-Read Flash Host Controller

This block is the host-side sequencer that reads 16-bit-aligned data from a serial NOR flash with the quad-I/O word-read command. A client asks for data by giving a 24-bit start address, a byte count and a flag that chooses whether the flash should stay in continuous read mode afterwards. The controller drives chip select, the serial clock (SPI mode 0, idle low) and four IO lines, each with its own output enable. Read bytes come back on a valid/ready stream. While the stream is stalled, the serial clock is stretched, so no byte is ever dropped.

Each access has a fixed sequence. First comes the 8-bit opcode on IO0. Next, the address and a mode byte are sent four bits per clock. Two dummy clocks follow, during which every IO line is released. Then data arrives as nibbles. The controller keeps track of whether the last mode byte left the flash in continuous mode. When it did, the next access leaves out the opcode phase. On request, the controller can also send a short exit sequence that takes the flash back to opcode-first operation. Requests that are malformed, or that arrive while quad operation is not enabled, are refused with an error pulse.

Top module: `qspi_word_reader`

## Requirements
- R1: When continuous mode is not active, an access starts with opcode 8'hE7 on IO0, most significant bit first, over 8 serial clocks. During these clocks only IO0 is enabled.
- R2: The 24-bit address follows over 6 clocks, most significant nibble first. In each nibble, IO3 carries the highest bit and IO0 the lowest.
- R3: The mode byte follows over 2 clocks. It is 8'h20 (bits 5:4 = 2'b10) when the request's continuous flag is set, and 8'h00 otherwise. Two dummy clocks come next. From the first dummy clock until chip select rises, io_oe is 4'b0000.
- R4: Each data byte takes 2 clocks. The high nibble is sampled first, with IO3 as the top bit of each nibble. Exactly req_len bytes are delivered, in address order, on rd_data.
- R5: After an access whose mode byte was 8'h20, cont_active is 1, and the next access goes straight to the address phase with no opcode clocks.
- R6: A pulse on exit_req while idle produces 8 clocks with IO0 driven to 1 and only IO0 enabled. It then clears cont_active, so the next access starts with the opcode again.
- R7: A request with an odd address, a zero length, or quad_enabled low is refused. err goes high for exactly one cycle and chip select stays high.
- R8: Chip select stays high for at least two system cycles between transactions, and sck is low whenever chip select is high.
- R9: While rd_valid is high and rd_ready is low, rd_valid stays high and rd_data stays stable. The serial clock pauses, so no byte is lost.
- R10: After reset, cs_n is 1, sck is 0, io_oe is 0, rd_valid is 0, cont_active is 0 and req_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial clock runs at half this rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| quad_enabled | input | 1 | The flash's quad enable bit is known to be set |
| req_valid | input | 1 | Read request valid |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_addr | input | 24 | Start byte address (must be even) |
| req_len | input | LEN_W | Number of bytes to read (must be nonzero) |
| req_cont | input | 1 | Leave the flash in continuous read mode after this access |
| exit_req | input | 1 | Send the continuous-mode exit sequence |
| err | output | 1 | One-cycle pulse when a request is refused |
| cont_active | output | 1 | The flash is believed to be in continuous read mode |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Values driven on IO3..IO0 |
| io_oe | output | 4 | Per-line output enables for IO3..IO0 |
| io_in | input | 4 | Values read from IO3..IO0 |
| rd_valid | output | 1 | Read byte valid |
| rd_ready | input | 1 | Consumer accepts the read byte |
| rd_data | output | 8 | Read byte |

## Verification
Five properties are checked on every cycle: sck stays low while chip select is high, chip select is never high for just a single cycle, a refusal never coincides with bus activity, every transaction begins with at least one IO line driven, and the read stream holds still under backpressure. The bench uses a behavioural flash model to cover everything else. That includes the exact bit order of the opcode, address and mode byte, the release of the IO lines before data, the assembly of data bytes, and skipping the opcode after a continuous-mode access. It also covers the exit sequence and its effect on the following access, since each of these depends on a whole transaction's worth of clocks.

// File: rtl/qspi_word_reader.sv
module qspi_word_reader #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_enabled,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_cont,
  input  logic             exit_req,
  output logic             err,
  output logic             cont_active,
  output logic             sck,
  output logic             cs_n,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data
);
  typedef enum logic [2:0] {S_IDLE, S_OPC, S_SHIFT, S_DUMMY, S_DATA, S_EXIT, S_GAP} st_t;
  localparam logic [7:0] OPCODE   = 8'hE7;
  localparam logic [7:0] MODE_ON  = 8'h20;
  localparam logic [7:0] MODE_OFF = 8'h00;

  st_t             st;
  logic            ph;
  logic [2:0]      cnt;
  logic [31:0]     sh;
  logic [LEN_W-1:0] left;
  logic            keep;
  logic [3:0]      hi;
  logic [2:0]      lim;

  wire busy    = st inside {S_OPC, S_SHIFT, S_DUMMY, S_DATA, S_EXIT};
  wire stall   = (st == S_DATA) && !ph && cnt[0] && rd_valid && !rd_ready;
  wire end_clk = busy && ph;
  wire accept  = req_valid && req_ready;
  wire bad_req = !quad_enabled || req_addr[0] || (req_len == '0);

  assign cs_n      = !busy;
  assign sck       = busy && ph;
  assign req_ready = (st == S_IDLE) && !exit_req;

  always_comb begin
    unique case (st)
      S_OPC, S_SHIFT, S_EXIT: lim = 3'd7;
      default:                lim = 3'd1;
    endcase
  end

  always_comb begin
    io_out = 4'b0000;
    io_oe  = 4'b0000;
    unique case (st)
      S_OPC:   begin io_oe = 4'b0001; io_out = {3'b000, OPCODE[3'd7 - cnt]}; end
      S_SHIFT: begin io_oe = 4'b1111; io_out = sh[31:28]; end
      S_EXIT:  begin io_oe = 4'b0001; io_out = 4'b0001; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      ph          <= 1'b0;
      cnt         <= '0;
      sh          <= '0;
      left        <= '0;
      keep        <= 1'b0;
      hi          <= '0;
      err         <= 1'b0;
      cont_active <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      err <= 1'b0;
      if (rd_valid && rd_ready) rd_valid <= 1'b0;
      ph <= (busy && !stall) ? !ph : (stall ? ph : 1'b0);

      unique case (st)
        S_IDLE: begin
          cnt <= '0;
          if (exit_req) begin
            st <= S_EXIT;
          end else if (accept) begin
            if (bad_req) begin
              err <= 1'b1;
            end else begin
              sh   <= {req_addr[23:1], 1'b0, req_cont ? MODE_ON : MODE_OFF};
              keep <= req_cont;
              left <= req_len;
              st   <= cont_active ? S_SHIFT : S_OPC;
            end
          end
        end
        S_GAP: st <= S_IDLE;
        default: begin
          if (end_clk) begin
            if (st == S_SHIFT) sh <= {sh[27:0], 4'b0000};
            if (st == S_DATA) begin
              if (!cnt[0]) hi <= io_in;
              else begin
                rd_data  <= {hi, io_in};
                rd_valid <= 1'b1;
              end
            end
            if (cnt == lim) begin
              cnt <= '0;
              unique case (st)
                S_OPC:   st <= S_SHIFT;
                S_SHIFT: begin st <= S_DUMMY; cont_active <= keep; end
                S_DUMMY: st <= S_DATA;
                S_EXIT:  begin st <= S_GAP; cont_active <= 1'b0; end
                default: begin
                  if (left == 1) st <= S_GAP;
                  else left <= left - 1'b1;
                end
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  p_sck_low_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);
  p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |=> cs_n);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (cs_n && !sck));
  p_first_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (io_oe != 4'b0000));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/qspi_word_reader_tb_top.sv
module qspi_word_reader_tb_top;
  localparam int LEN_W = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic quad_enabled = 1'b1, req_valid = 1'b0, req_cont = 1'b0, exit_req = 1'b0, rd_ready = 1'b1;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, err, cont_active, sck, cs_n, rd_valid;
  logic [3:0] io_out, io_oe, io_in = 4'h0;
  logic [7:0] rd_data;

  always #4 clk = ~clk;

  qspi_word_reader #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .quad_enabled(quad_enabled),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_cont(req_cont), .exit_req(exit_req), .err(err), .cont_active(cont_active),
    .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data));

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] fdat(input logic [23:0] x);
    return x[7:0] ^ x[15:8] ^ 8'hA5;
  endfunction

  // behavioural flash model, bus lines pulled up when released
  wire [3:0] bus = (io_oe & io_out) | ~io_oe;
  bit flash_cont = 0, saw_opc = 0;
  int ncl = 0, base = 0, oe_viol = 0;
  logic [7:0] m_opc, m_mode;
  logic [23:0] m_addr;
  logic [3:0] oe_seen;
  bit io0_ones;

  always @(negedge cs_n) begin
    ncl = 0; m_opc = '0; m_addr = '0; m_mode = '0; oe_viol = 0;
    saw_opc = !flash_cont; base = saw_opc ? 8 : 0;
    oe_seen = '0; io0_ones = 1;
  end

  always @(posedge sck) if (!cs_n) begin
    oe_seen = oe_seen | io_oe;
    if (!(io_oe[0] && io_out[0])) io0_ones = 0;
    if (saw_opc && ncl < 8) m_opc = {m_opc[6:0], bus[0]};
    else if (ncl < base + 6) m_addr = {m_addr[19:0], bus};
    else if (ncl < base + 8) m_mode = {m_mode[3:0], bus};
    else if (io_oe != 4'b0000) oe_viol++;
    ncl++;
  end

  always @(negedge sck) if (!cs_n && ncl >= base + 10) begin
    int k;
    logic [7:0] b;
    k = ncl - (base + 10);
    b = fdat(m_addr + 24'(k / 2));
    io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
  end

  always @(posedge cs_n) if (ncl >= base + 8) flash_cont = (m_mode[5:4] == 2'b10);

  // stream collector and backpressure monitor
  logic [7:0] rxq[$];
  bit bp_mode = 0, held = 0;
  logic [7:0] held_data;
  int hold_viol = 0, cyc = 0;
  always @(negedge clk) begin
    bit rdy;
    cyc++;
    if (held && !(rd_valid && rd_data == held_data)) hold_viol++;
    rdy = bp_mode ? (cyc % 3 == 0) : 1'b1;
    rd_ready = rdy;
    if (rd_valid && rdy) rxq.push_back(rd_data);
    held = rd_valid && !rdy;
    held_data = rd_data;
  end

  // chip select gap and idle clock monitor
  int hi_run = 0, min_gap = 1000, sck_idle_viol = 0;
  bit seen_txn = 0;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sck) sck_idle_viol++;
    if (cs_n) hi_run++;
    else begin
      if (hi_run > 0 && seen_txn && hi_run < min_gap) min_gap = hi_run;
      if (hi_run > 0) seen_txn = 1;
      hi_run = 0;
    end
  end

  task automatic issue(input logic [23:0] a, input int len, input bit cont);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_addr = a; req_len = LEN_W'(len); req_cont = cont; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_read(input logic [23:0] a, input int len, input bit cont);
    rxq.delete();
    issue(a, len, cont);
    wait (cs_n == 1'b0);
    wait (cs_n == 1'b1);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_data(input logic [23:0] a, input int len, input string req);
    chk(rxq.size() == len, req, "byte count", rxq.size(), len);
    for (int i = 0; i < len && i < rxq.size(); i++)
      chk(rxq[i] == fdat(a + 24'(i)), req, $sformatf("byte %0d", i), rxq[i], fdat(a + 24'(i)));
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cs_n == 1'b1, "R10", "cs_n", cs_n, 1);
    chk(sck == 1'b0, "R10", "sck", sck, 0);
    chk(io_oe == 4'b0, "R10", "io_oe", io_oe, 0);
    chk(rd_valid == 1'b0, "R10", "rd_valid", rd_valid, 0);
    chk(cont_active == 1'b0, "R10", "cont_active", cont_active, 0);
    chk(req_ready == 1'b1, "R10", "req_ready", req_ready, 1);
  endtask

  task automatic t_plain;
    run_read(24'h012344, 6, 0);
    chk(saw_opc == 1, "R1", "opcode phase present", saw_opc, 1);
    chk(m_opc == 8'hE7, "R1", "opcode", m_opc, 8'hE7);
    chk(m_addr == 24'h012344, "R2", "address", m_addr, 24'h012344);
    chk(m_mode == 8'h00, "R3", "mode byte", m_mode, 0);
    chk(oe_viol == 0, "R3", "driven during dummy/data", oe_viol, 0);
    check_data(24'h012344, 6, "R4");
    chk(cont_active == 0, "R5", "cont_active after plain", cont_active, 0);
  endtask

  task automatic t_cont;
    run_read(24'hABCDE0, 4, 1);
    chk(m_opc == 8'hE7, "R1", "opcode before cont", m_opc, 8'hE7);
    chk(m_mode == 8'h20, "R3", "mode byte cont", m_mode, 8'h20);
    chk(cont_active == 1, "R5", "cont_active set", cont_active, 1);
    check_data(24'hABCDE0, 4, "R4");
    run_read(24'h000100, 2, 1);
    chk(saw_opc == 0, "R5", "opcode skipped", saw_opc, 0);
    chk(ncl == 14, "R5", "clock count without opcode", ncl, 14);
    chk(m_addr == 24'h000100, "R2", "address in cont", m_addr, 24'h000100);
    check_data(24'h000100, 2, "R5");
  endtask

  task automatic t_exit;
    @(negedge clk);
    exit_req = 1'b1;
    @(negedge clk);
    exit_req = 1'b0;
    wait (cs_n == 1'b0);
    wait (cs_n == 1'b1);
    repeat (4) @(negedge clk);
    chk(ncl == 8, "R6", "exit clock count", ncl, 8);
    chk(oe_seen == 4'b0001, "R6", "exit enables", oe_seen, 1);
    chk(io0_ones == 1, "R6", "IO0 high throughout", io0_ones, 1);
    chk(cont_active == 0, "R6", "cont_active cleared", cont_active, 0);
    chk(flash_cont == 0, "R6", "flash left cont", flash_cont, 0);
    run_read(24'h3000FE, 2, 0);
    chk(saw_opc == 1 && m_opc == 8'hE7, "R6", "opcode after exit", m_opc, 8'hE7);
    check_data(24'h3000FE, 2, "R6");
  endtask

  task automatic t_reject(input logic [23:0] a, input int len, input bit qe, input string what);
    int low_cs;
    quad_enabled = qe;
    issue(a, len, 0);
    chk(err == 1, "R7", {what, " err pulse"}, err, 1);
    @(negedge clk);
    chk(err == 0, "R7", {what, " err one cycle"}, err, 0);
    low_cs = 0;
    repeat (6) begin @(negedge clk); if (!cs_n) low_cs++; end
    chk(low_cs == 0, "R7", {what, " no bus activity"}, low_cs, 0);
    quad_enabled = 1'b1;
  endtask

  task automatic t_bp;
    bp_mode = 1;
    run_read(24'h05A5A0, 8, 0);
    bp_mode = 0;
    check_data(24'h05A5A0, 8, "R9");
    chk(hold_viol == 0, "R9", "stream hold", hold_viol, 0);
  endtask

  task automatic final_report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    final_report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_cont();
    t_exit();
    t_reject(24'h000011, 4, 1, "odd address");
    t_reject(24'h000010, 0, 1, "zero length");
    t_reject(24'h000010, 4, 0, "quad disabled");
    t_bp();
    chk(min_gap >= 2, "R8", "cs_n high gap", min_gap, 2);
    chk(sck_idle_viol == 0, "R8", "sck high with cs_n high", sck_idle_viol, 0);
    final_report();
  end
endmodule